// File: doc/BRIEF.md
# Programmable Interval Counter Channel (Rate and Square-Wave Modes)

One down-counting channel of an interval timer. It is paced by a count-clock enable (`cnt_en`), which typically pulses once every counter period of a roughly 1.19 MHz timebase. Software writes a 16-bit initial count together with a mode select in a single strobe. In rate mode the output stays high and drops for one counter period in each cycle of N periods, which makes it usable as a periodic refresh-request strobe. In square-wave mode the output divides the count clock by N, which makes it usable as a tone source.

A written count never takes effect on the edge of the write. The write arms the channel. The next count-clock enable loads the count, so the new value is applied one counter period later. After that the channel reloads by itself every cycle. A gate input acts as the speaker enable: in square-wave mode it masks the output, and in rate mode it is ignored. Counting continues while the gate is low.

Control is a three-state machine. `ST_IDLE` is the state after reset, before any count has been written. `ST_ARMED` means a count has been written and is waiting for the next enable. `ST_RUN` means the channel is counting. The transitions are:
- IDLE→ARMED on a write.
- ARMED→RUN on the first enable without a write.
- RUN→ARMED on any new write.
- ARMED→ARMED on a repeated write.

Top module: `tone_refresh_timer`

## Requirements
- R1: After reset the output is high and the state is idle. Count-clock enables do not change the output until a count is written.
- R2: A write forces the output high (in square-wave mode with the gate low, the masked output reads low). The count takes effect at the first `cnt_en` after the write, and that enable counts as period 0 of the new waveform.
- R3: Rate mode (`wr_mode`=0) with count N≥2: the output is low exactly in period k where k mod N = N−1 (k counted in enables from the load), and high in all other periods.
- R4: In rate mode the channel reloads N after the low period and keeps repeating the cycle with no further write.
- R5: Square-wave mode (`wr_mode`=1) with even N≥2: the output is high for N/2 periods, then low for N/2 periods, repeating. It starts high at the load.
- R6: Square-wave mode with odd N≥3: the high half lasts (N+1)/2 periods and the low half lasts (N−1)/2 periods, so the full period is still N.
- R7: A written count of 0 acts as 65536 (2^CW).
- R8: In square-wave mode the output is the waveform ANDed with `gate`. A low gate does not pause counting, so the phase continues unbroken when the gate returns high.
- R9: In rate mode `gate` has no effect on the output.
- R10: A write while running abandons the current cycle. The new count starts from its own period 0 at the next enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Count-clock enable, one pulse per counter period |
| wr_stb | input | 1 | Write strobe for the count and mode |
| wr_mode | input | 1 | 0 = rate mode, 1 = square-wave mode |
| wr_count | input | CW | Initial count, where 0 means 2^CW |
| gate | input | 1 | Output enable in square-wave mode |
| tmr_out | output | 1 | Timer output |

## Verification
Every counter fault shows up at the output within one waveform period. A load that is one enable early or late shifts every low strobe and every toggle by one period. A wrong reload value or a missed reload stretches or shortens the following cycle. Odd-count errors show up as an unequal half on the very first toggle. The bench predicts the output level after each enable from N, the mode and the gate alone. It therefore reports any such fault at the first enable where the level differs.

// File: rtl/tone_refresh_pkg.sv
package tone_refresh_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2
    } tmr_state_e;

    typedef enum logic {
        MODE_RATE   = 1'b0,
        MODE_SQUARE = 1'b1
    } tmr_mode_e;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
    import tone_refresh_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_stb,
    input  logic       cnt_en,
    output tmr_state_e state,
    output logic       load,
    output logic       step
);
    tmr_state_e state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (wr_stb) state_nx = ST_ARMED;
            ST_ARMED: if (!wr_stb && cnt_en) state_nx = ST_RUN;
            ST_RUN:   if (wr_stb) state_nx = ST_ARMED;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        load = (state == ST_ARMED) && cnt_en && !wr_stb;
        step = (state == ST_RUN)   && cnt_en && !wr_stb;
    end

    // R2: running is reached only through the armed state
    a_r2_run_via_armed: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) && $past(state) != ST_RUN |-> $past(state) == ST_ARMED);
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tone_refresh_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_stb,
    input  logic          wr_mode,
    input  logic [CW-1:0] wr_count,
    input  logic          load,
    input  logic          step,
    output logic          wave,
    output tmr_mode_e     mode
);
    localparam int KW = CW + 1;

    logic [KW-1:0] n_q, cnt, cnt_nx, hi_len, lo_len;
    logic          wave_nx;

    assign hi_len = n_q + {{CW{1'b0}}, n_q[0]};
    assign lo_len = n_q - {{CW{1'b0}}, n_q[0]};

    always_comb begin
        cnt_nx  = cnt;
        wave_nx = wave;
        if (wr_stb) begin
            wave_nx = 1'b1;
        end else if (load) begin
            wave_nx = 1'b1;
            cnt_nx  = (mode == MODE_SQUARE) ? hi_len : n_q;
        end else if (step) begin
            unique case (mode)
                MODE_RATE: begin
                    if (!wave || cnt <= KW'(1)) begin
                        cnt_nx  = n_q;
                        wave_nx = 1'b1;
                    end else begin
                        cnt_nx  = cnt - KW'(1);
                        wave_nx = (cnt - KW'(1)) != KW'(1);
                    end
                end
                MODE_SQUARE: begin
                    if (cnt <= KW'(2)) begin
                        wave_nx = !wave;
                        cnt_nx  = wave ? lo_len : hi_len;
                    end else begin
                        cnt_nx  = cnt - KW'(2);
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_q  <= '0;
            cnt  <= '0;
            wave <= 1'b1;
            mode <= MODE_RATE;
        end else begin
            cnt  <= cnt_nx;
            wave <= wave_nx;
            if (wr_stb) begin
                mode <= tmr_mode_e'(wr_mode);
                n_q  <= (wr_count == '0) ? {1'b1, {CW{1'b0}}} : {1'b0, wr_count};
            end
        end
    end

    // R2: the counter holds between enables
    a_r2_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !load && !step |=> $stable(cnt));
    // R3: a rate-mode low period ends at the next enable
    a_r3_low_one_period: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RATE) && step && !wave |=> wave);
    // R5: the waveform moves only on enables or writes
    a_r5_wave_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !load && !step && !wr_stb |=> $stable(wave));
    // R7: a loaded rate-mode count is never zero
    a_r7_nonzero_count: assert property (@(posedge clk) disable iff (!rst_n)
        load && (mode == MODE_RATE) |=> cnt != '0);
endmodule

// File: rtl/tone_refresh_timer.sv
module tone_refresh_timer
    import tone_refresh_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cnt_en,
    input  logic          wr_stb,
    input  logic          wr_mode,
    input  logic [CW-1:0] wr_count,
    input  logic          gate,
    output logic          tmr_out
);
    tmr_state_e state;
    tmr_mode_e  mode;
    logic       load, step, wave;

    tmr_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_stb (wr_stb),
        .cnt_en (cnt_en),
        .state  (state),
        .load   (load),
        .step   (step)
    );

    tmr_core #(.CW(CW)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stb   (wr_stb),
        .wr_mode  (wr_mode),
        .wr_count (wr_count),
        .load     (load),
        .step     (step),
        .wave     (wave),
        .mode     (mode)
    );

    assign tmr_out = (mode == MODE_SQUARE) ? (wave & gate) : wave;

    // R1: no waveform activity before the first write
    a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> wave);
endmodule

// File: tb/tone_refresh_timer_tb.sv
`timescale 1ns/1ps
module tone_refresh_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_en = 1'b0;
    logic        wr_stb = 1'b0;
    logic        wr_mode = 1'b0;
    logic [15:0] wr_count = '0;
    logic        gate = 1'b1;
    logic        tmr_out;

    int n_run = 0;
    int n_fail = 0;

    typedef struct {
        logic  exp;
        string tag;
    } item_t;
    item_t q[$];

    always #2.5 clk = ~clk;

    tone_refresh_timer #(.CW(16)) u_dut (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_stb(wr_stb),
        .wr_mode(wr_mode), .wr_count(wr_count), .gate(gate), .tmr_out(tmr_out)
    );

    task automatic check(input logic act, input logic exp, input string tag);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: tmr_out=%0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    // monitor: after each enable edge, pop and compare
    always @(posedge clk) begin
        if (rst_n && cnt_en && q.size() > 0) begin
            @(negedge clk);
            begin
                item_t it;
                it = q.pop_front();
                check(tmr_out, it.exp, it.tag);
            end
        end
    end

    // driver primitives (entered and left at a negedge)
    task automatic en_pulse(input logic exp, input string tag, input int gap);
        item_t it;
        it.exp = exp;
        it.tag = tag;
        q.push_back(it);
        cnt_en = 1'b1;
        @(negedge clk);
        cnt_en = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic wr(input logic m, input logic [15:0] n, input string tag);
        wr_stb = 1'b1; wr_mode = m; wr_count = n;
        @(negedge clk);
        wr_stb = 1'b0;
        check(tmr_out, m ? gate : 1'b1, tag);
    endtask

    task automatic run(input logic m, input int n, input int k0, input int k1,
                       input int gap, input string tag);
        for (int k = k0; k < k1; k++) begin
            logic e;
            string t;
            if (m) e = ((k % n) < ((n + 1) / 2)) && gate;
            else   e = (k % n) != (n - 1);
            t = (tag == "") ? ((k < n) ? "R3" : "R4") : tag;
            en_pulse(e, t, gap);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: tmr_out=%0b expected run to finish", tmr_out);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(tmr_out, 1'b1, "R1");
        for (int i = 0; i < 3; i++) en_pulse(1'b1, "R1", 2);

        // rate mode, N=5, with reload
        wr(1'b0, 16'd5, "R2");
        run(1'b0, 5, 0, 13, 2, "");

        // gate ignored in rate mode
        gate = 1'b0;
        wr(1'b0, 16'd3, "R9");
        run(1'b0, 3, 0, 9, 1, "R9");
        gate = 1'b1;

        // square, even and odd
        wr(1'b1, 16'd6, "R2");
        run(1'b1, 6, 0, 18, 2, "R5");
        wr(1'b1, 16'd7, "R2");
        run(1'b1, 7, 0, 21, 1, "R6");
        wr(1'b1, 16'd3, "R2");
        run(1'b1, 3, 0, 9, 0, "R6");

        // gate masks square wave but counting continues
        wr(1'b1, 16'd4, "R8");
        run(1'b1, 4, 0, 4, 1, "R8");
        gate = 1'b0;
        run(1'b1, 4, 4, 9, 1, "R8");
        gate = 1'b1;
        run(1'b1, 4, 9, 16, 1, "R8");

        // load latency: no enable -> nothing moves
        wr(1'b0, 16'd2, "R2");
        repeat (6) @(negedge clk);
        check(tmr_out, 1'b1, "R2");
        run(1'b0, 2, 0, 6, 3, "R2");

        // rewrite while running
        wr(1'b0, 16'd6, "R10");
        run(1'b0, 6, 0, 4, 1, "R10");
        wr(1'b0, 16'd3, "R10");
        run(1'b0, 3, 0, 7, 1, "R10");

        // count 0 means 65536
        wr(1'b0, 16'd0, "R7");
        run(1'b0, 65536, 0, 65538, 0, "R7");

        repeat (4) @(negedge clk);
        if (q.size() != 0) begin
            n_run++;
            n_fail++;
            $display("FAIL scoreboard: %0d items left expected 0", q.size());
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule